// File: doc/BRIEF.md
# Arbitrated Dual-Port RAM

This block is a synchronous memory of 2048 words by 8 bits with two identical ports, left and right. Each port reaches every location and has its own enable, write select, output enable, address, write data, registered read data and an active-low busy flag. Traffic at different addresses runs on both ports at once with no interaction.

When both ports are enabled on the same address, a small arbiter grants the location to one port. The port that was already on that address in the previous cycle wins. On a tie, where both arrive in the same cycle, the left port wins. The losing port sees its busy flag go low and its writes are dropped. Once the address conflict ends, its flag rises again, and a write it still holds then lands in the array. Data written through one port can be read back through the other.

The arbiter is a three-state machine. `ARB_IDLE` means no conflict. `ARB_LEFT_OWNS` and `ARB_RIGHT_OWNS` name the granted port. Transitions: `GRANT_LEFT` (IDLE to LEFT_OWNS, on a conflict that starts in a tie or with left already present), `GRANT_RIGHT` (IDLE to RIGHT_OWNS, on a conflict where only right was already present), `RELEASE` (either owner state to IDLE, when the conflict ends). An owner state is kept while the conflict lasts.

Top module: `dpr_arb_ram`

## Requirements
- R1: After reset both busy flags are high (1) and both read data outputs are zero.
- R2: A port that writes a word and then reads the same address sees that word on its read data one cycle after the read cycle.
- R3: A word written by one port is returned by the other port when that port reads the address in any later cycle; reads return the contents before any write in the same cycle.
- R4: Read data is zero in the cycle after one in which the port's enable or output enable was low.
- R5: A conflict is both enables high with equal addresses. A port is "present" in a cycle when it was enabled on the same address in the previous cycle. If a conflict starts with only one port present, the other port's busy flag is low from the next cycle.
- R6: If a conflict starts with neither port present (a tie), the right port's busy flag is low from the next cycle and the left flag stays high.
- R7: The granted port keeps priority for as long as the conflict lasts, even if it stops writing.
- R8: A losing port's write has no effect on the array, both in the cycle the conflict starts and in every cycle its busy flag is low.
- R9: The busy flag rises one cycle after the conflict ends, and a write that the former loser still holds then completes.
- R10: Accesses at different addresses never lower a busy flag.
- R11: The two busy flags are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_ce | input | 1 | Left port enable |
| l_we | input | 1 | Left write select (1 = write) |
| l_oe | input | 1 | Left output enable |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left registered read data |
| l_busy_n | output | 1 | Left busy flag, active low |
| r_ce | input | 1 | Right port enable |
| r_we | input | 1 | Right write select (1 = write) |
| r_oe | input | 1 | Right output enable |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read data |
| r_busy_n | output | 1 | Right busy flag, active low |

## Verification
The bench builds the block with ADDR_W = 6 and DATA_W = 8. The 64-word array then fits a full shadow copy in the bench, and distinct conflict and non-conflict addresses are easy to choose. Arbitration does not depend on the depth, so every state, transition, tie rule and release-then-complete case is exercised just as at the default 2048 words.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    typedef enum logic [1:0] {
        ARB_IDLE       = 2'd0,
        ARB_LEFT_OWNS  = 2'd1,
        ARB_RIGHT_OWNS = 2'd2
    } arb_state_e;

    localparam int unsigned NUM_PORTS = 2;
    localparam int unsigned PORT_L    = 0;
    localparam int unsigned PORT_R    = 1;
endpackage

// File: rtl/dpr_port_track.sv
// Marks a port as "present" when it stays enabled on the same address
// as in the previous cycle.
module dpr_port_track #(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic [ADDR_W-1:0] addr,
    output logic              present
);
    logic              prev_ce;
    logic [ADDR_W-1:0] prev_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_ce   <= 1'b0;
            prev_addr <= '0;
        end else begin
            prev_ce   <= ce;
            prev_addr <= addr;
        end
    end

    assign present = ce && prev_ce && (addr == prev_addr);
endmodule

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
    import dpr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic conflict,
    input  logic l_present,
    input  logic r_present,
    output logic l_block,
    output logic r_block,
    output logic l_busy_n,
    output logic r_busy_n
);
    arb_state_e state_q, state_d;
    logic       right_first;

    assign right_first = r_present && !l_present;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (conflict) state_d = right_first ? ARB_RIGHT_OWNS : ARB_LEFT_OWNS;
            end
            ARB_LEFT_OWNS: begin
                if (!conflict) state_d = ARB_IDLE;
            end
            ARB_RIGHT_OWNS: begin
                if (!conflict) state_d = ARB_IDLE;
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        l_busy_n = 1'b1;
        r_busy_n = 1'b1;
        l_block  = 1'b0;
        r_block  = 1'b0;
        unique case (state_q)
            ARB_IDLE: begin
                l_block = conflict && right_first;
                r_block = conflict && !right_first;
            end
            ARB_LEFT_OWNS: begin
                r_busy_n = 1'b0;
                r_block  = 1'b1;
            end
            ARB_RIGHT_OWNS: begin
                l_busy_n = 1'b0;
                l_block  = 1'b1;
            end
            default: begin
                l_block = 1'b1;
                r_block = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/dpr_array.sv
module dpr_array
    import dpr_pkg::*;
#(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_PORTS-1:0]              wr_en,
    input  logic [NUM_PORTS-1:0]              rd_en,
    input  logic [NUM_PORTS-1:0]              out_en,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  addr,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]  wdata,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]  rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (wr_en[p]) mem[addr[p]] <= wdata[p];
        end
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_rd
        logic [DATA_W-1:0] rd_q;
        logic              vis_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rd_q  <= '0;
                vis_q <= 1'b0;
            end else begin
                vis_q <= out_en[g];
                if (rd_en[g]) rd_q <= mem[addr[g]];
            end
        end

        assign rdata[g] = vis_q ? rd_q : '0;
    end
endmodule

// File: rtl/dpr_arb_ram.sv
module dpr_arb_ram
    import dpr_pkg::*;
#(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_ce,
    input  logic              l_we,
    input  logic              l_oe,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_busy_n,
    input  logic              r_ce,
    input  logic              r_we,
    input  logic              r_oe,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_busy_n
);
    logic [NUM_PORTS-1:0]             ce_v, we_v, oe_v, present_v, block_v;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v;
    logic [NUM_PORTS-1:0][DATA_W-1:0] wdata_v, rdata_v;
    logic                             conflict;

    assign ce_v    = {r_ce, l_ce};
    assign we_v    = {r_we, l_we};
    assign oe_v    = {r_oe, l_oe};
    assign addr_v  = {r_addr, l_addr};
    assign wdata_v = {r_wdata, l_wdata};

    assign conflict = l_ce && r_ce && (l_addr == r_addr);

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_trk
        dpr_port_track #(.ADDR_W(ADDR_W)) u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .ce      (ce_v[g]),
            .addr    (addr_v[g]),
            .present (present_v[g])
        );
    end

    dpr_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .conflict  (conflict),
        .l_present (present_v[PORT_L]),
        .r_present (present_v[PORT_R]),
        .l_block   (block_v[PORT_L]),
        .r_block   (block_v[PORT_R]),
        .l_busy_n  (l_busy_n),
        .r_busy_n  (r_busy_n)
    );

    dpr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ce_v & we_v & ~block_v),
        .rd_en  (ce_v),
        .out_en (ce_v & oe_v),
        .addr   (addr_v),
        .wdata  (wdata_v),
        .rdata  (rdata_v)
    );

    assign l_rdata = rdata_v[PORT_L];
    assign r_rdata = rdata_v[PORT_R];
endmodule

// File: rtl/dpr_arb_ram_chk.sv
module dpr_arb_ram_chk #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_ce,
    input logic              l_oe,
    input logic [ADDR_W-1:0] l_addr,
    input logic [DATA_W-1:0] l_rdata,
    input logic              l_busy_n,
    input logic              r_ce,
    input logic              r_oe,
    input logic [ADDR_W-1:0] r_addr,
    input logic [DATA_W-1:0] r_rdata,
    input logic              r_busy_n
);
    logic              match, prv_match, prv_l_ce, prv_r_ce, tie_start;
    logic [ADDR_W-1:0] prv_l_addr, prv_r_addr;

    assign match = l_ce && r_ce && (l_addr == r_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prv_match  <= 1'b0;
            prv_l_ce   <= 1'b0;
            prv_r_ce   <= 1'b0;
            prv_l_addr <= '0;
            prv_r_addr <= '0;
        end else begin
            prv_match  <= match;
            prv_l_ce   <= l_ce;
            prv_r_ce   <= r_ce;
            prv_l_addr <= l_addr;
            prv_r_addr <= r_addr;
        end
    end

    assign tie_start = match && !prv_match
                    && !(prv_l_ce && prv_l_addr == l_addr)
                    && !(prv_r_ce && prv_r_addr == r_addr);

    AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> (l_busy_n && r_busy_n)); // R1

    AST_L_DARK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(l_ce && l_oe) |-> (l_rdata == '0)); // R4

    AST_R_DARK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(r_ce && r_oe) |-> (r_rdata == '0)); // R4

    AST_TIE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        tie_start |=> (!r_busy_n && l_busy_n)); // R6

    AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_busy_n && match) |=> !r_busy_n); // R7

    AST_L_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_busy_n && match) |=> !l_busy_n); // R7

    AST_R_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_busy_n && !match) |=> r_busy_n); // R9

    AST_L_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_busy_n && !match) |=> l_busy_n); // R9

    AST_NO_FALSE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !prv_match |-> (l_busy_n && r_busy_n)); // R10

    AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (l_busy_n || r_busy_n)); // R11
endmodule

bind dpr_arb_ram dpr_arb_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .l_ce     (l_ce),
    .l_oe     (l_oe),
    .l_addr   (l_addr),
    .l_rdata  (l_rdata),
    .l_busy_n (l_busy_n),
    .r_ce     (r_ce),
    .r_oe     (r_oe),
    .r_addr   (r_addr),
    .r_rdata  (r_rdata),
    .r_busy_n (r_busy_n)
);

// File: tb/sim_dpr_arb_ram.sv
module sim_dpr_arb_ram;
    localparam int unsigned AW = 6;
    localparam int unsigned DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          l_ce = 0, l_we = 0, l_oe = 0;
    logic          r_ce = 0, r_we = 0, r_oe = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic          l_busy_n, r_busy_n;

    logic [DW-1:0] shadow [1 << AW];
    int            n_checks = 0;
    int            n_fail   = 0;

    always #4 clk = ~clk;  // 125 MHz

    dpr_arb_ram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .l_ce(l_ce), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_busy_n(l_busy_n),
        .r_ce(r_ce), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_busy_n(r_busy_n)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic l_drive(input logic ce, input logic we, input logic oe, input logic [AW-1:0] a, input logic [DW-1:0] d);
        l_ce = ce; l_we = we; l_oe = oe; l_addr = a; l_wdata = d;
    endtask

    task automatic r_drive(input logic ce, input logic we, input logic oe, input logic [AW-1:0] a, input logic [DW-1:0] d);
        r_ce = ce; r_we = we; r_oe = oe; r_addr = a; r_wdata = d;
    endtask

    task automatic idle_both();
        l_drive(0, 0, 0, '0, '0);
        r_drive(0, 0, 0, '0, '0);
    endtask

    task automatic t_reset();
        check("R1", "l_busy_n", l_busy_n, 1);
        check("R1", "r_busy_n", r_busy_n, 1);
        check("R1", "l_rdata", l_rdata, 0);
        check("R1", "r_rdata", r_rdata, 0);
    endtask

    task automatic t_same_port();
        l_drive(1, 1, 0, 6'd3, 8'hA5); shadow[3] = 8'hA5;
        tick();
        l_drive(1, 0, 1, 6'd3, '0);
        tick();
        check("R2", "left readback", l_rdata, shadow[3]);
        l_drive(1, 0, 0, 6'd3, '0);
        tick();
        check("R4", "left rdata with oe low", l_rdata, 0);
        idle_both();
        tick();
    endtask

    task automatic t_cross_read();
        l_drive(1, 1, 0, 6'd7, 8'h3C); shadow[7] = 8'h3C;
        tick();
        l_drive(0, 0, 0, '0, '0);
        r_drive(1, 0, 1, 6'd7, '0);
        tick();
        check("R3", "right reads left data", r_rdata, shadow[7]);
        idle_both();
        tick();
        check("R4", "right rdata with ce low", r_rdata, 0);
    endtask

    task automatic t_tie();
        l_drive(1, 1, 0, 6'd10, 8'h11);
        r_drive(1, 1, 0, 6'd10, 8'h22);
        shadow[10] = 8'h11;
        tick();
        check("R6", "tie r_busy_n", r_busy_n, 0);
        check("R6", "tie l_busy_n", l_busy_n, 1);
        l_drive(1, 0, 0, 6'd10, '0);
        tick();
        check("R7", "winner idle keeps grant", r_busy_n, 0);
        idle_both();
        tick();
        check("R9", "tie release r_busy_n", r_busy_n, 1);
        l_drive(1, 0, 1, 6'd10, '0);
        tick();
        check("R8", "tie loser write dropped", l_rdata, shadow[10]);
        idle_both();
        tick();
    endtask

    task automatic t_late_write();
        r_drive(1, 1, 0, 6'd20, 8'h40); shadow[20] = 8'h40;
        tick();
        r_drive(1, 0, 1, 6'd20, '0);
        l_drive(1, 1, 0, 6'd20, 8'h77);
        tick();
        check("R5", "late left busy_n", l_busy_n, 0);
        check("R5", "present right busy_n", r_busy_n, 1);
        tick();
        check("R7", "left still busy", l_busy_n, 0);
        check("R8", "blocked write absent", r_rdata, shadow[20]);
        r_drive(0, 0, 0, '0, '0);
        tick();
        check("R9", "left busy released", l_busy_n, 1);
        shadow[20] = 8'h77;
        tick();
        l_drive(0, 0, 0, '0, '0);
        r_drive(1, 0, 1, 6'd20, '0);
        tick();
        check("R9", "held write completed", r_rdata, shadow[20]);
        idle_both();
        tick();
    endtask

    task automatic t_disjoint();
        l_drive(1, 1, 0, 6'd30, 8'h5A); shadow[30] = 8'h5A;
        r_drive(1, 1, 0, 6'd31, 8'hC3); shadow[31] = 8'hC3;
        tick();
        check("R10", "disjoint l_busy_n", l_busy_n, 1);
        check("R10", "disjoint r_busy_n", r_busy_n, 1);
        l_drive(1, 0, 1, 6'd31, '0);
        r_drive(1, 0, 1, 6'd30, '0);
        tick();
        check("R3", "left reads right word", l_rdata, shadow[31]);
        check("R3", "right reads left word", r_rdata, shadow[30]);
        idle_both();
        tick();
    endtask

    initial begin
        #(8 * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_same_port();
        t_cross_read();
        t_tie();
        t_late_write();
        t_disjoint();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule